// File: doc/BRIEF.md
# Test Mode Decode and Pin Multiplexer

This block turns the chip's two active-low test strap pins, plus a reset pin level that is sampled during power-on reset, into one operating mode: normal, debug, board-test high impedance, or oscillator/PLL test. It drives the mode flags to the rest of the chip.

It also sits between the functional port registers and the pads of three ports: a general port A, a column port and a small port E. It overrides the pad data and direction of selected pins when a test mode is active.

A separate software observation switch, a single bit of the system control register, overlays the CPU's wait-stretched clock and its two interrupt request lines onto port E. The high-impedance mode reaches every pad enable through combinational logic only. It switches every pad off without a clock and without touching any stored state.

Top module: `tmode_pinmux_top`

## Requirements
- R1: While `por_n` is low, the reset pin level `rst_lvl` is sampled on every clock. Once `por_n` is high, the sampled level is held unchanged until the next power-on reset, whatever `rst_lvl` does.
- R2: With both test pins high the block is in normal mode. `dbg_en`, `hiz_active` and `clk_test_active` are 0, every pad takes its functional data and enable, `pll_tsel`=0, `osc_en`=1, `pll_en`=1 and `pll_bypass`=0.
- R3: With both test pins low and a held reset level of 1, the block is in debug mode. `dbg_en`=1 and the ports keep their functional values.
- R4: With both test pins low and a held reset level of 0, `hiz_active`=1 and every pad enable of all three ports is 0. This follows a test pin change combinationally, before any clock edge.
- R5: High-impedance mode changes no stored state. Pad data stays at the values the ports would otherwise drive. After normal mode, re-entering both-low selects high impedance again, with `dbg_en` still 0.
- R6: With exactly one test pin low, `clk_test_active`=1. Port A bits 5, 4, 3 and 0 have their enables forced to 0. `pll_tsel`, `osc_en`, `pll_en` and `pll_bypass` then follow the pad inputs of bits 5, 4, 3 and 0 respectively.
- R7: In oscillator/PLL test mode, column port bits 0, 1, 2, 4 and 6 are enabled and driven with `rtc_osc_clk`, `sec_tick`, `pll_div_clk`, `slow_div_clk` and `pll_test_clk` respectively. Other column bits stay functional.
- R8: With `obs_ctl`=1, port E bits 0, 1 and 2 are enabled and driven with `cpu_wclk`, `fiq_req_n` and `irq_req_n`. With `obs_ctl`=0 they are functional. `obs_active` equals `obs_ctl`.
- R9: High impedance takes priority over every overlay. With `obs_ctl`=1 in high-impedance mode, all enables are still 0.
- R10: While `por_n` is low, `dbg_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| test0_n | input | 1 | Test strap pin 0, active low |
| test1_n | input | 1 | Test strap pin 1, active low |
| rst_lvl | input | 1 | Reset pin level sampled during power-on reset |
| obs_ctl | input | 1 | Software observation enable from the system control register |
| cpu_wclk | input | 1 | Wait-stretched CPU clock to observe |
| fiq_req_n | input | 1 | Fast interrupt request to observe |
| irq_req_n | input | 1 | Normal interrupt request to observe |
| rtc_osc_clk | input | 1 | Real-time oscillator output |
| sec_tick | input | 1 | 1 Hz divider output |
| pll_div_clk | input | 1 | Divided PLL main clock |
| slow_div_clk | input | 1 | Clock derived from the divided PLL clock |
| pll_test_clk | input | 1 | PLL test clock |
| pa_func_do | input | PA_W | Port A functional data |
| pa_func_oe | input | PA_W | Port A functional enables |
| pa_di | input | PA_W | Port A pad inputs |
| col_func_do | input | COL_W | Column port functional data |
| col_func_oe | input | COL_W | Column port functional enables |
| pe_func_do | input | PE_W | Port E functional data |
| pe_func_oe | input | PE_W | Port E functional enables |
| pa_do | output | PA_W | Port A pad data |
| pa_oe | output | PA_W | Port A pad enables |
| col_do | output | COL_W | Column port pad data |
| col_oe | output | COL_W | Column port pad enables |
| pe_do | output | PE_W | Port E pad data |
| pe_oe | output | PE_W | Port E pad enables |
| dbg_en | output | 1 | Processor debug enable |
| hiz_active | output | 1 | Board-test high-impedance mode flag |
| clk_test_active | output | 1 | Oscillator/PLL test mode flag |
| obs_active | output | 1 | Observation overlay flag |
| pll_tsel | output | 1 | PLL test select |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_bypass | output | 1 | PLL bypass |

## Verification
The observation overlay and the high-impedance kill can both be active in the same cycle, since one comes from a register bit and the other from the strap pins. The bench raises `obs_ctl` and then pulls both test pins low with a held reset level of 0. The reference model expects every enable at 0 while port E data still carries the observed signals. A mid-cycle pin change is also checked before the next clock edge, to show that the kill does not wait for a clock.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL  = 2'd0,
    TM_DEBUG   = 2'd1,
    TM_HIZ     = 2'd2,
    TM_CLKTEST = 2'd3
  } tmode_e;

  // port A bits read as PLL controls in clock test mode
  localparam int PA_TSEL_BIT = 5;
  localparam int PA_OSC_BIT  = 4;
  localparam int PA_PLL_BIT  = 3;
  localparam int PA_BYP_BIT  = 0;

  // column bits carrying clock observation in clock test mode
  localparam int COL_RTC_BIT  = 0;
  localparam int COL_SEC_BIT  = 1;
  localparam int COL_PDIV_BIT = 2;
  localparam int COL_SDIV_BIT = 4;
  localparam int COL_PTST_BIT = 6;

  // port E bits carrying observed CPU signals
  localparam int PE_CLK_BIT = 0;
  localparam int PE_FIQ_BIT = 1;
  localparam int PE_IRQ_BIT = 2;

  // mode choice from the two strap pins and the held reset level
  function automatic tmode_e tmode_pick(input logic t0_n, input logic t1_n,
                                        input logic strap);
    tmode_e m;
    unique case ({t0_n, t1_n})
      2'b11:   m = TM_NORMAL;
      2'b00:   m = strap ? TM_DEBUG : TM_HIZ;
      default: m = TM_CLKTEST;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] bit_at(input int pos);
    return 32'd1 << pos;
  endfunction

endpackage

// File: rtl/tmode_strap_latch.sv
module tmode_strap_latch (
  input  logic clk,
  input  logic por_n,
  input  logic rst_lvl,
  output logic strap_q
);
  // tracks the pin during power-on reset, frozen afterwards
  always_ff @(posedge clk) begin
    if (!por_n) strap_q <= rst_lvl;
  end
endmodule

// File: rtl/tmode_decode.sv
module tmode_decode
  import tmode_pkg::*;
(
  input  logic por_n,
  input  logic test0_n,
  input  logic test1_n,
  input  logic strap_q,
  output logic dbg_en,
  output logic hiz_kill,
  output logic clk_test
);
  tmode_e mode;

  always_comb mode = tmode_pick(test0_n, test1_n, strap_q);

  // no clock on any of these paths
  assign dbg_en   = por_n & (mode == TM_DEBUG);
  assign hiz_kill = (mode == TM_HIZ);
  assign clk_test = (mode == TM_CLKTEST);
endmodule

// File: rtl/tmode_port_mux.sv
module tmode_port_mux #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic [W-1:0] func_do,
  input  logic [W-1:0] func_oe,
  input  logic [W-1:0] ovr_do,
  input  logic [W-1:0] ovr_oe,
  input  logic         ovr_en,
  input  logic         hiz,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] take;
  logic [W-1:0] sel_oe;

  assign take   = {W{ovr_en}} & MASK;
  assign pad_do = (ovr_do & take) | (func_do & ~take);
  assign sel_oe = (ovr_oe & take) | (func_oe & ~take);
  assign pad_oe = hiz ? '0 : sel_oe;
endmodule

// File: rtl/tmode_pinmux_top.sv
module tmode_pinmux_top
  import tmode_pkg::*;
#(
  parameter int PA_W  = 8,
  parameter int COL_W = 8,
  parameter int PE_W  = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             test0_n,
  input  logic             test1_n,
  input  logic             rst_lvl,
  input  logic             obs_ctl,
  input  logic             cpu_wclk,
  input  logic             fiq_req_n,
  input  logic             irq_req_n,
  input  logic             rtc_osc_clk,
  input  logic             sec_tick,
  input  logic             pll_div_clk,
  input  logic             slow_div_clk,
  input  logic             pll_test_clk,
  input  logic [PA_W-1:0]  pa_func_do,
  input  logic [PA_W-1:0]  pa_func_oe,
  input  logic [PA_W-1:0]  pa_di,
  input  logic [COL_W-1:0] col_func_do,
  input  logic [COL_W-1:0] col_func_oe,
  input  logic [PE_W-1:0]  pe_func_do,
  input  logic [PE_W-1:0]  pe_func_oe,
  output logic [PA_W-1:0]  pa_do,
  output logic [PA_W-1:0]  pa_oe,
  output logic [COL_W-1:0] col_do,
  output logic [COL_W-1:0] col_oe,
  output logic [PE_W-1:0]  pe_do,
  output logic [PE_W-1:0]  pe_oe,
  output logic             dbg_en,
  output logic             hiz_active,
  output logic             clk_test_active,
  output logic             obs_active,
  output logic             pll_tsel,
  output logic             osc_en,
  output logic             pll_en,
  output logic             pll_bypass
);
  localparam logic [31:0] PA_M32  = bit_at(PA_TSEL_BIT) | bit_at(PA_OSC_BIT)
                                  | bit_at(PA_PLL_BIT)  | bit_at(PA_BYP_BIT);
  localparam logic [31:0] COL_M32 = bit_at(COL_RTC_BIT) | bit_at(COL_SEC_BIT)
                                  | bit_at(COL_PDIV_BIT) | bit_at(COL_SDIV_BIT)
                                  | bit_at(COL_PTST_BIT);
  localparam logic [31:0] PE_M32  = bit_at(PE_CLK_BIT) | bit_at(PE_FIQ_BIT)
                                  | bit_at(PE_IRQ_BIT);
  localparam logic [PA_W-1:0]  PA_MASK  = PA_M32[PA_W-1:0];
  localparam logic [COL_W-1:0] COL_MASK = COL_M32[COL_W-1:0];
  localparam logic [PE_W-1:0]  PE_MASK  = PE_M32[PE_W-1:0];

  logic strap_q;
  logic hiz_kill;
  logic clk_test;
  logic [COL_W-1:0] col_ovr_do;
  logic [PE_W-1:0]  pe_ovr_do;
  logic unused_pa_in;

  tmode_strap_latch u_strap (
    .clk     (clk),
    .por_n   (por_n),
    .rst_lvl (rst_lvl),
    .strap_q (strap_q)
  );

  tmode_decode u_dec (
    .por_n    (por_n),
    .test0_n  (test0_n),
    .test1_n  (test1_n),
    .strap_q  (strap_q),
    .dbg_en   (dbg_en),
    .hiz_kill (hiz_kill),
    .clk_test (clk_test)
  );

  assign hiz_active      = hiz_kill;
  assign clk_test_active = clk_test;
  assign obs_active      = obs_ctl;

  // PLL controls come from port A pads only in clock test mode
  assign pll_tsel   = clk_test ? pa_di[PA_TSEL_BIT] : 1'b0;
  assign osc_en     = clk_test ? pa_di[PA_OSC_BIT]  : 1'b1;
  assign pll_en     = clk_test ? pa_di[PA_PLL_BIT]  : 1'b1;
  assign pll_bypass = clk_test ? pa_di[PA_BYP_BIT]  : 1'b0;
  assign unused_pa_in = ^(pa_di & ~PA_MASK);

  // per-bit overlay sources
  for (genvar i = 0; i < COL_W; i++) begin : g_col
    if (i == COL_RTC_BIT)       begin : g_s assign col_ovr_do[i] = rtc_osc_clk;  end
    else if (i == COL_SEC_BIT)  begin : g_s assign col_ovr_do[i] = sec_tick;     end
    else if (i == COL_PDIV_BIT) begin : g_s assign col_ovr_do[i] = pll_div_clk;  end
    else if (i == COL_SDIV_BIT) begin : g_s assign col_ovr_do[i] = slow_div_clk; end
    else if (i == COL_PTST_BIT) begin : g_s assign col_ovr_do[i] = pll_test_clk; end
    else                        begin : g_s assign col_ovr_do[i] = 1'b0;         end
  end

  for (genvar i = 0; i < PE_W; i++) begin : g_pe
    if (i == PE_CLK_BIT)      begin : g_s assign pe_ovr_do[i] = cpu_wclk;  end
    else if (i == PE_FIQ_BIT) begin : g_s assign pe_ovr_do[i] = fiq_req_n; end
    else if (i == PE_IRQ_BIT) begin : g_s assign pe_ovr_do[i] = irq_req_n; end
    else                      begin : g_s assign pe_ovr_do[i] = 1'b0;      end
  end

  // port A: test bits turn into inputs, data untouched
  tmode_port_mux #(.W(PA_W), .MASK(PA_MASK)) u_pa (
    .func_do (pa_func_do),
    .func_oe (pa_func_oe),
    .ovr_do  (pa_func_do),
    .ovr_oe  ('0),
    .ovr_en  (clk_test),
    .hiz     (hiz_kill),
    .pad_do  (pa_do),
    .pad_oe  (pa_oe)
  );

  tmode_port_mux #(.W(COL_W), .MASK(COL_MASK)) u_col (
    .func_do (col_func_do),
    .func_oe (col_func_oe),
    .ovr_do  (col_ovr_do),
    .ovr_oe  ('1),
    .ovr_en  (clk_test),
    .hiz     (hiz_kill),
    .pad_do  (col_do),
    .pad_oe  (col_oe)
  );

  tmode_port_mux #(.W(PE_W), .MASK(PE_MASK)) u_pe (
    .func_do (pe_func_do),
    .func_oe (pe_func_oe),
    .ovr_do  (pe_ovr_do),
    .ovr_oe  ('1),
    .ovr_en  (obs_ctl),
    .hiz     (hiz_kill),
    .pad_do  (pe_do),
    .pad_oe  (pe_oe)
  );

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(strap_q));

  // R4
  hiz_all_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    hiz_active |-> (pa_oe == '0 && col_oe == '0 && pe_oe == '0));

  // R3
  dbg_from_straps_chk: assert property (@(posedge clk) disable iff (!por_n)
    dbg_en |-> (!test0_n && !test1_n && strap_q));

  // R6
  mode_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({dbg_en, hiz_active, clk_test_active}));

  // R8
  obs_drive_chk: assert property (@(posedge clk) disable iff (!por_n)
    (obs_active && !hiz_active) |-> (pe_oe[PE_IRQ_BIT:PE_CLK_BIT] == 3'b111));

  // R10
  dbg_off_in_por_chk: assert property (@(posedge clk) !por_n |-> !dbg_en);
endmodule

// File: tb/tb_tmode_pinmux_top.sv
`timescale 1ns/100ps
module tb_tmode_pinmux_top;
  localparam int PA_W = 8, COL_W = 8, PE_W = 4;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic por_n, test0_n, test1_n, rst_lvl, obs_ctl;
  logic cpu_wclk, fiq_req_n, irq_req_n;
  logic rtc_osc_clk, sec_tick, pll_div_clk, slow_div_clk, pll_test_clk;
  logic [PA_W-1:0] pa_func_do, pa_func_oe, pa_di;
  logic [COL_W-1:0] col_func_do, col_func_oe;
  logic [PE_W-1:0] pe_func_do, pe_func_oe;
  logic [PA_W-1:0] pa_do, pa_oe;
  logic [COL_W-1:0] col_do, col_oe;
  logic [PE_W-1:0] pe_do, pe_oe;
  logic dbg_en, hiz_active, clk_test_active, obs_active;
  logic pll_tsel, osc_en, pll_en, pll_bypass;

  tmode_pinmux_top #(.PA_W(PA_W), .COL_W(COL_W), .PE_W(PE_W)) dut (.*);

  int checks = 0, errors = 0;
  string tag = "R2";
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model: held level and expected outputs
  logic m_strap;
  always @(posedge clk) if (!por_n) m_strap <= rst_lvl;

  task automatic compare_all(input string req);
    bit e_norm, e_dbg, e_hiz, e_clkt;
    logic [31:0] e_pa_oe, e_col_do, e_col_oe, e_pe_do, e_pe_oe;
    e_norm = test0_n && test1_n;
    e_dbg  = !test0_n && !test1_n && m_strap;
    e_hiz  = !test0_n && !test1_n && !m_strap;
    e_clkt = !e_norm && !(!test0_n && !test1_n);
    e_pa_oe = 32'(pa_func_oe); e_col_do = 32'(col_func_do); e_col_oe = 32'(col_func_oe);
    e_pe_do = 32'(pe_func_do); e_pe_oe = 32'(pe_func_oe);
    if (e_clkt) begin
      e_pa_oe[5] = 0; e_pa_oe[4] = 0; e_pa_oe[3] = 0; e_pa_oe[0] = 0;
      e_col_do[0] = rtc_osc_clk; e_col_do[1] = sec_tick; e_col_do[2] = pll_div_clk;
      e_col_do[4] = slow_div_clk; e_col_do[6] = pll_test_clk;
      e_col_oe[0] = 1; e_col_oe[1] = 1; e_col_oe[2] = 1; e_col_oe[4] = 1; e_col_oe[6] = 1;
    end
    if (obs_ctl) begin
      e_pe_do[0] = cpu_wclk; e_pe_do[1] = fiq_req_n; e_pe_do[2] = irq_req_n;
      e_pe_oe[2:0] = 3'b111;
    end
    if (e_hiz) begin e_pa_oe = 0; e_col_oe = 0; e_pe_oe = 0; end
    chk(req, "dbg_en", 32'(dbg_en), 32'(e_dbg && por_n));
    chk(req, "hiz_active", 32'(hiz_active), 32'(e_hiz));
    chk(req, "clk_test_active", 32'(clk_test_active), 32'(e_clkt));
    chk(req, "obs_active", 32'(obs_active), 32'(obs_ctl));
    chk(req, "pa_do", 32'(pa_do), 32'(pa_func_do));
    chk(req, "pa_oe", 32'(pa_oe), e_pa_oe);
    chk(req, "col_do", 32'(col_do), e_col_do);
    chk(req, "col_oe", 32'(col_oe), e_col_oe);
    chk(req, "pe_do", 32'(pe_do), e_pe_do);
    chk(req, "pe_oe", 32'(pe_oe), e_pe_oe);
    chk(req, "pll_ctl", {28'd0, pll_tsel, osc_en, pll_en, pll_bypass},
        e_clkt ? {28'd0, pa_di[5], pa_di[4], pa_di[3], pa_di[0]} : 32'h6);
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!por_n) chk("R10", "dbg_en in por", 32'(dbg_en), 32'd0);
      else compare_all(tag);
    end
  end

  task automatic randomize_data();
    pa_func_do = PA_W'($urandom); pa_func_oe = PA_W'($urandom); pa_di = PA_W'($urandom);
    col_func_do = COL_W'($urandom); col_func_oe = COL_W'($urandom);
    pe_func_do = PE_W'($urandom); pe_func_oe = PE_W'($urandom);
    {cpu_wclk, fiq_req_n, irq_req_n} = 3'($urandom);
    {rtc_osc_clk, sec_tick, pll_div_clk, slow_div_clk, pll_test_clk} = 5'($urandom);
  endtask

  task automatic run(input string req, input logic t0, input logic t1,
                     input logic obs, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #0.5;
      tag = req; test0_n = t0; test1_n = t1; obs_ctl = obs;
      randomize_data();
    end
  endtask

  task automatic power_on(input logic lvl);
    @(posedge clk); #0.5;
    por_n = 0; rst_lvl = lvl; test0_n = 1; test1_n = 1; obs_ctl = 0;
    repeat (4) @(posedge clk);
    #0.5 por_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    por_n = 0; rst_lvl = 1; test0_n = 1; test1_n = 1; obs_ctl = 0;
    randomize_data();
    power_on(1'b1);
    run("R2", 1, 1, 0, 20);
    run("R3", 0, 0, 0, 20);
    run("R6", 0, 1, 0, 20);
    run("R7", 1, 0, 0, 20);
    run("R8", 1, 1, 1, 20);
    run("R8", 0, 1, 1, 10);
    // R1: reset pin toggles after release; debug must persist
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #0.5;
      tag = "R1"; rst_lvl = ~rst_lvl; test0_n = 0; test1_n = 0; randomize_data();
    end
    // second power-on with the reset pin low
    power_on(1'b0);
    run("R2", 1, 1, 0, 5);
    // R4: mid-cycle change, checked before any clock edge
    @(posedge clk); #0.5;
    tag = "R4"; pa_func_oe = '1; col_func_oe = '1; pe_func_oe = '1;
    #0.5 test0_n = 0; test1_n = 0;
    #0.5;
    chk("R4", "async oe off", {8'd0, pa_oe, col_oe, 4'd0, pe_oe}, 32'd0);
    chk("R4", "async hiz flag", 32'(hiz_active), 32'd1);
    run("R4", 0, 0, 0, 10);
    // R9: observation overlay requested during high impedance
    run("R9", 0, 0, 1, 15);
    // R5: leave and re-enter; held level unchanged, data kept
    run("R5", 1, 1, 0, 5);
    rst_lvl = 1;
    run("R5", 0, 0, 0, 10);
    run("R2", 1, 1, 0, 5);
    @(posedge clk); #1;
    finish_run();
  end
endmodule